// File: doc/BRIEF.md
# Packed Byte Permute and Align Unit

This block is a 128-bit vector datapath that performs one of two byte-level rearrangements per request, chosen by a one-bit opcode. In permute mode, every output byte is chosen from the first operand by a selector byte taken from the matching lane of the second operand. In align mode, the two operands are joined into a 32-byte value, which is shifted right by a whole number of bytes. The low 16 bytes of that shifted value form the result.

A request is presented by raising `in_valid` together with the opcode, both operands and an 8-bit byte count. The result and its valid flag appear one clock later from a register. Throughout this block, byte k of any vector bus occupies bits 8k+7 down to 8k. Reset is synchronous and active low.

Top module: `bpa_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` and `out_data` are both cleared to 0 on that edge, whatever `in_valid` holds.
- R2: `out_valid` at a rising edge takes the value `in_valid` had at that edge. A result therefore appears exactly one cycle after its request, including when requests come back to back.
- R3: With `in_op` = 0 (permute), output byte i equals byte `src_b[i][3:0]` of `src_a`. For example, data bytes 1..16 with selectors {4,128,4,3,24,12,6,19,12,5,5,10,4,1,8,0} give {5,0,5,4,9,13,7,4,13,6,6,11,5,2,9,1}.
- R4: In permute mode, a selector byte with bit 7 set forces its output byte to 0. If all 16 selectors have bit 7 set, the result is all zero.
- R5: In permute mode, selector bits 6:4 have no effect on the result. For example, selector 0x18 picks byte 8 and selector 0x13 picks byte 3.
- R6: With `in_op` = 1 (align), the result is bytes n..n+15 of the 32-byte value whose bytes 0..15 are `src_b` and whose bytes 16..31 are `src_a`, where n = `shift_n` lies between 1 and 15.
- R7: In align mode, a count of 0 returns `src_b` unchanged and a count of 16 returns `src_a` unchanged.
- R8: In align mode, a count n from 17 to 32 returns `src_a` shifted down by n−16 bytes, with zero bytes filled in at the top. A count of 32 returns all zeros.
- R9: In align mode, any count above 32, up to 255, returns all zeros.
- R10: When `in_valid` is low at a rising edge, `out_data` keeps its previous value, even if the operands change.
- R11: In permute mode, `shift_n` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| in_op | input | 1 | 0 = byte permute, 1 = byte align |
| src_a | input | 128 | Permute: table of data bytes; align: upper half of the joined value |
| src_b | input | 128 | Permute: selector bytes; align: lower half of the joined value |
| shift_n | input | 8 | Align byte count, unsigned |
| out_data | output | 128 | Registered result |
| out_valid | output | 1 | `out_data` holds a new result this cycle |

## Verification
Both operations are purely combinational ahead of a single register, so a faulty lane mux, shifter stage or saturation decode shows up as a wrong byte on `out_data` in the cycle after the request that uses it. Nothing stays hidden for longer than that. Because a broken barrel stage only shows at counts that have its bit set, the counts cover every stage bit alone and in combination, plus the boundaries 0, 15, 16, 17, 31, 32, 33 and 255. A broken capture enable shows one cycle after an idle request, as a changed `out_data` or a stray `out_valid`.

// File: rtl/bpa_pkg.sv
// Package: shared sizes and opcode encoding for the byte permute/align unit.
// Assumes byte k of every vector sits at bits [8k+7:8k].
package bpa_pkg;
    localparam int BPA_LANES  = 16;
    localparam int BPA_BYTE_W = 8;
    localparam int BPA_CNT_W  = 8;

    typedef enum logic {
        OP_PERMUTE = 1'b0,
        OP_ALIGN   = 1'b1
    } bpa_op_e;
endpackage

// File: rtl/bpa_permute.sv
// Module: bpa_permute
// Table-driven byte permute. Each output lane uses the selector byte in the
// same lane. The low index bits of that byte pick a byte of the table, and the
// top bit forces the lane to zero. The bits in between are not used.
// Assumes LANES is a power of two and BYTE_W > $clog2(LANES).
module bpa_permute #(
    parameter int LANES  = bpa_pkg::BPA_LANES,
    parameter int BYTE_W = bpa_pkg::BPA_BYTE_W,
    localparam int VEC_W = LANES * BYTE_W,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [VEC_W-1:0] table_vec,
    input  logic [VEC_W-1:0] sel_vec,
    output logic [VEC_W-1:0] perm_vec
);
    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        logic [BYTE_W-1:0] sel_byte;
        logic [IDX_W-1:0]  pick_idx;
        logic [BYTE_W-1:0] picked;

        assign sel_byte = sel_vec[lane*BYTE_W +: BYTE_W];
        assign pick_idx = sel_byte[IDX_W-1:0];

        // Select one table byte using the low index bits of the selector.
        always_comb begin
            picked = table_vec[pick_idx*BYTE_W +: BYTE_W];
        end

        assign perm_vec[lane*BYTE_W +: BYTE_W] = sel_byte[BYTE_W-1] ? '0 : picked;
    end
endmodule

// File: rtl/bpa_align.sv
// Module: bpa_align
// Byte-granular funnel shift. The value {hi_vec, lo_vec} is shifted right by
// shift_cnt bytes through log2(2*LANES) barrel stages, and the low LANES bytes
// are returned. Counts of 2*LANES or more give zero.
// Assumes 2*LANES is a power of two and CNT_W > $clog2(2*LANES).
module bpa_align #(
    parameter int LANES  = bpa_pkg::BPA_LANES,
    parameter int BYTE_W = bpa_pkg::BPA_BYTE_W,
    parameter int CNT_W  = bpa_pkg::BPA_CNT_W,
    localparam int VEC_W  = LANES * BYTE_W,
    localparam int CAT_W  = 2 * VEC_W,
    localparam int STAGES = $clog2(2 * LANES)
) (
    input  logic [VEC_W-1:0] hi_vec,
    input  logic [VEC_W-1:0] lo_vec,
    input  logic [CNT_W-1:0] shift_cnt,
    output logic [VEC_W-1:0] aligned_vec
);
    logic [CAT_W-1:0] stage_val [0:STAGES];
    logic             past_end;

    assign stage_val[0] = {hi_vec, lo_vec};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Each stage shifts by 2**s bytes when bit s of the count is set.
        assign stage_val[s+1] = shift_cnt[s] ? (stage_val[s] >> ((1 << s) * BYTE_W))
                                             : stage_val[s];
    end

    // Any count bit above the stage range moves everything out of the window.
    assign past_end = |shift_cnt[CNT_W-1:STAGES];

    assign aligned_vec = past_end ? '0 : stage_val[STAGES][VEC_W-1:0];
endmodule

// File: rtl/bpa_unit.sv
// Module: bpa_unit (top)
// Picks the permute or align result by opcode and registers it together with
// a valid flag, so that results follow requests by exactly one cycle.
// out_data only loads on a valid request. Reset is synchronous, active low.
module bpa_unit #(
    parameter int LANES  = bpa_pkg::BPA_LANES,
    parameter int BYTE_W = bpa_pkg::BPA_BYTE_W,
    parameter int CNT_W  = bpa_pkg::BPA_CNT_W,
    localparam int VEC_W = LANES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [CNT_W-1:0] shift_n,
    output logic [VEC_W-1:0] out_data,
    output logic             out_valid
);
    import bpa_pkg::*;

    logic [VEC_W-1:0] perm_res;
    logic [VEC_W-1:0] align_res;
    logic [VEC_W-1:0] next_res;
    logic [LANES-1:0] kill_bits;
    bpa_op_e          op_q;

    assign op_q = bpa_op_e'(in_op);

    bpa_permute #(.LANES(LANES), .BYTE_W(BYTE_W)) perm_i (
        .table_vec (src_a),
        .sel_vec   (src_b),
        .perm_vec  (perm_res)
    );

    bpa_align #(.LANES(LANES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) align_i (
        .hi_vec      (src_a),
        .lo_vec      (src_b),
        .shift_cnt   (shift_n),
        .aligned_vec (align_res)
    );

    // Choose the result of the requested operation.
    always_comb begin
        next_res = (op_q == OP_ALIGN) ? align_res : perm_res;
    end

    // Register the result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_res;
            end
        end
    end

    // Collect the top bit of every selector lane, used by the checks below.
    for (genvar l = 0; l < LANES; l++) begin : g_kill
        assign kill_bits[l] = src_b[l*BYTE_W + BYTE_W - 1];
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R10
    AST_ALL_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op && (&kill_bits)) |=> (out_data == '0)); // R4
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op && (shift_n == '0)) |=> (out_data == $past(src_b))); // R7
    AST_FAR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op && (shift_n > CNT_W'(2*LANES))) |=> (out_data == '0)); // R9
endmodule

// File: tb/bpa_unit_tb_top.sv
// Scoreboard bench: the driver pushes expected results into a queue, and the
// monitor pops and compares them whenever out_valid is seen.
module bpa_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_op;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic [7:0]   shift_n;
    logic [127:0] out_data;
    logic         out_valid;

    int n_vec = 0;
    int n_bad = 0;
    logic [127:0] exp_q [$];
    string        tag_q [$];

    always #5 clk = ~clk;

    bpa_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .src_a(src_a), .src_b(src_b), .shift_n(shift_n),
        .out_data(out_data), .out_valid(out_valid)
    );

    function automatic logic [127:0] mdl_perm(logic [127:0] d, logic [127:0] c);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] s;
            int k;
            s = c[i*8 +: 8];
            k = int'(s) % 16;
            r[i*8 +: 8] = s[7] ? 8'h00 : d[k*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [127:0] mdl_align(logic [127:0] a, logic [127:0] b, int n);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) begin
            int idx;
            idx = i + n;
            if (idx < 16)      r[i*8 +: 8] = b[idx*8 +: 8];
            else if (idx < 32) r[i*8 +: 8] = a[(idx-16)*8 +: 8];
            else               r[i*8 +: 8] = 8'h00;
        end
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_exp(logic op, logic [127:0] a, logic [127:0] b,
                            logic [7:0] n, logic [127:0] exp, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        src_a    = a;
        src_b    = b;
        shift_n  = n;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic send(logic op, logic [127:0] a, logic [127:0] b,
                        logic [7:0] n, string tag);
        logic [127:0] e;
        e = op ? mdl_align(a, b, int'(n)) : mdl_perm(a, b);
        send_exp(op, a, b, n, e, tag);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
        src_a    = rnd128();
        src_b    = rnd128();
        shift_n  = 8'($urandom);
    endtask

    // Monitor: compare each result against the head of the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 stray out_valid", {127'b0, out_valid}, 128'b0);
                end else begin
                    logic [127:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, out_data, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] a, b, hold_exp;
        logic [127:0] cnt_data;
        rst_n = 1'b0; in_valid = 1'b1; in_op = 1'b0;
        src_a = '1; src_b = '0; shift_n = '0;
        repeat (3) @(negedge clk);
        // R1: reset clears both outputs even with a request present
        check("R1 out_valid in reset", {127'b0, out_valid}, 128'b0);
        check("R1 out_data in reset", out_data, 128'b0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        cnt_data = 128'h100F_0E0D_0C0B_0A09_0807_0605_0403_0201;
        // R3: the published permute vector
        send_exp(1'b0, cnt_data, 128'h0008_0104_0A05_050C_1306_0C18_0304_8004, 8'd0,
                 128'h0109_0205_0B06_060D_0407_0D09_0405_0005, "R3 table vector");
        // R4: every selector killed
        send_exp(1'b0, rnd128(), {16{8'h8F}}, 8'd0, 128'b0, "R4 all lanes zeroed");
        send(1'b0, cnt_data, {8{8'hF3, 8'h05}}, 8'd0, "R4 mixed kill");
        // R5: middle selector bits ignored; 0x18 picks byte 8, 0x13 picks byte 3
        send_exp(1'b0, cnt_data, {8{8'h13, 8'h18}}, 8'd0, {8{8'h04, 8'h09}}, "R5 bits 6:4 ignored");
        send(1'b0, rnd128(), {16{8'h7A}}, 8'd0, "R5 all middle bits set");
        // R11: shift count ignored in permute mode
        a = rnd128(); b = rnd128();
        send(1'b0, a, b, 8'd0, "R11 permute count 0");
        send(1'b0, a, b, 8'd17, "R11 permute count 17");
        send(1'b0, a, b, 8'd255, "R11 permute count 255");
        // R6: in-window counts, each stage bit alone and combined
        a = cnt_data; b = rnd128();
        send(1'b1, a, b, 8'd1, "R6 align 1");
        send(1'b1, a, b, 8'd2, "R6 align 2");
        send(1'b1, a, b, 8'd4, "R6 align 4");
        send(1'b1, a, b, 8'd8, "R6 align 8");
        send(1'b1, a, b, 8'd11, "R6 align 11");
        send(1'b1, a, b, 8'd15, "R6 align 15");
        // R7: identity counts
        send_exp(1'b1, a, b, 8'd0, b, "R7 align 0 gives src_b");
        send_exp(1'b1, a, b, 8'd16, a, "R7 align 16 gives src_a");
        // R8: upper-half counts with zero fill
        send_exp(1'b1, a, b, 8'd17, {8'h00, cnt_data[127:8]}, "R8 align 17");
        send(1'b1, a, b, 8'd23, "R8 align 23");
        send_exp(1'b1, a, b, 8'd31, {120'b0, 8'h10}, "R8 align 31");
        send_exp(1'b1, a, b, 8'd32, 128'b0, "R8 align 32");
        // R9: saturated counts
        send_exp(1'b1, a, b, 8'd33, 128'b0, "R9 align 33");
        send_exp(1'b1, a, b, 8'd64, 128'b0, "R9 align 64");
        send_exp(1'b1, a, b, 8'd255, 128'b0, "R9 align 255");
        // R2: back-to-back random mix
        for (int i = 0; i < 200; i++) begin
            logic opr;
            opr = 1'($urandom);
            send(opr, rnd128(), rnd128(), 8'($urandom % 40), opr ? "R6 random align" : "R3 random permute");
        end
        // R10 and R2: idle cycle holds data and drops valid
        a = rnd128(); b = rnd128();
        hold_exp = mdl_align(a, b, 5);
        send(1'b1, a, b, 8'd5, "R6 before hold");
        go_idle();
        @(posedge clk);
        #1;
        check("R2 valid low after idle", {127'b0, out_valid}, 128'b0);
        check("R10 data held while idle", out_data, hold_exp);
        repeat (3) @(negedge clk);
        check("R10 data still held", out_data, hold_exp);
        check("R2 all results delivered", 128'(exp_q.size()), 128'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule